// File: doc/BRIEF.md
# Micro-operation cracker for a two-read, one-write register file

The cracker sits between instruction decode and issue. It accepts one decoded instruction at a time on a valid/ready handshake. It turns that instruction into a sequence of micro-operations, each of which writes at most one register. The register file behind it has two read ports and one write port. Instructions that produce two or more register results, or that need more than two source reads, leave as several consecutive micro-operations. The register write order is fixed for each instruction class.

Each outgoing micro-operation carries the following fields:
- a write-register number and a write enable;
- two read-register selects;
- a zero-based position within its instruction;
- a flag that marks the final micro-operation.

The output also uses a valid/ready handshake. While a sequence is still being emitted, the cracker refuses the next instruction. It accepts the next instruction in the same cycle that the final micro-operation is taken downstream. This lets single-micro-operation instructions stream at one per clock.

Instruction class encodings on `in_op`: 0 plain, 1 load, 2 load-multiple, 3 store-multiple, 4 double-word move, 5 divide, 6 multiply-accumulate, 7 store with register offset. Register fields are 5 bits wide. Read selects and write registers that a micro-operation does not use are driven as 0.

Top module: `uop_cracker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Class 0 emits one micro-operation: write in_rt with enable 1, read in_ra and in_rb.
- R3: Class 1 (load) emits one micro-operation when in_upd is 0: write in_rt, read in_ra. When in_upd is 1 it emits two: first write in_rt, then write in_ra (base). Both read in_ra.
- R4: Class 2 (load-multiple) of N words emits N micro-operations. Micro-operation k writes register (in_rt+k) mod 32 and reads in_ra. When in_upd is 1, one more micro-operation follows that writes in_ra and reads in_ra.
- R5: Class 3 (store-multiple) of N words emits N micro-operations. Micro-operation k has write enable 0, reads in_ra on port 1 and (in_rt+k) mod 32 on port 2. When in_upd is 1, one more micro-operation follows that writes in_ra and reads in_ra.
- R6: in_cnt gives N for classes 2 and 3. The values 1 to 8 and 12 are honoured. Every other value is treated as N = 1.
- R7: Class 4 (double-word move) emits two micro-operations. The first writes in_rt with bit 0 cleared and reads in_ra with bit 0 cleared. The second writes in_rt with bit 0 set and reads in_ra with bit 0 set.
- R8: Class 5 (divide) emits two micro-operations, both reading in_ra and in_rb. The first writes the quotient to in_rt and the second writes the remainder to in_rs.
- R9: Class 6 (multiply-accumulate) emits two micro-operations. The first reads in_ra and in_rb with write enable 0. The second reads in_rt and writes in_rt.
- R10: Class 7 (store with register offset) emits two micro-operations, both with write enable 0 and both reading in_ra on port 1. Port 2 reads in_rb in the first and the store data in_rt in the second.
- R11: out_idx counts 0, 1, 2, … within an instruction. out_last is 1 only on the final micro-operation. A one-micro-operation instruction shows index 0 with out_last set.
- R12: in_ready is 0 while a sequence is outstanding. The one exception is the cycle in which its last micro-operation is accepted with out_ready; in that cycle in_ready is 1.
- R13: While out_valid is 1 and out_ready is 0, every output field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Cracker can take an instruction this cycle |
| in_op | input | 3 | Instruction class |
| in_upd | input | 1 | Base-register update requested (classes 1 to 3) |
| in_cnt | input | 4 | Word count for multiple transfers |
| in_rt | input | 5 | Primary destination / first data register |
| in_rs | input | 5 | Secondary destination (divide remainder) |
| in_ra | input | 5 | First source / base register |
| in_rb | input | 5 | Second source / offset register |
| out_valid | output | 1 | Micro-operation present |
| out_ready | input | 1 | Downstream takes the micro-operation |
| out_wr_reg | output | 5 | Register written by this micro-operation |
| out_wr_en | output | 1 | Register write enable |
| out_rd1 | output | 5 | Read port 1 select |
| out_rd2 | output | 5 | Read port 2 select |
| out_idx | output | 4 | Zero-based position in the sequence |
| out_last | output | 1 | Final micro-operation of the instruction |

## Verification
Each class is issued directly with a free-flowing downstream, first alone and then back to back. This separates the write order within each class and also shows whether single-operation instructions stream without bubbles. Multiple transfers are issued with counts at 1, 8 and 12, with unsupported counts 0, 9, 13 and 15, and with a destination near 31. These show the count decode, the appended base write and the register-number wrap. A long run of random classes and fields under random downstream stalls then shows that fields hold under back-pressure. It also shows that the next instruction is taken exactly when the last micro-operation leaves.

// File: rtl/uopc_pkg.sv
package uopc_pkg;
    localparam int REG_W     = 5;
    localparam int CNT_W     = 4;
    localparam int IDX_W     = 4;
    localparam int GROUP_MAX = 8;   // contiguous supported word counts 1..GROUP_MAX
    localparam int GROUP_ALT = 12;  // one further supported word count

    typedef enum logic [2:0] {
        OP_PLAIN = 3'd0,
        OP_LOAD  = 3'd1,
        OP_LDM   = 3'd2,
        OP_STM   = 3'd3,
        OP_MOVD  = 3'd4,
        OP_DIV   = 3'd5,
        OP_MAC   = 3'd6,
        OP_STRR  = 3'd7
    } op_e;

    typedef struct packed {
        op_e              op;
        logic             upd;
        logic [CNT_W-1:0] cnt;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
    } instr_t;

    typedef struct packed {
        logic [REG_W-1:0] wr;
        logic             we;
        logic [REG_W-1:0] rd1;
        logic [REG_W-1:0] rd2;
    } uop_t;
endpackage

// File: rtl/uopc_len.sv
module uopc_len
    import uopc_pkg::*;
(
    input  op_e              op,
    input  logic             upd,
    input  logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] words,
    output logic [IDX_W-1:0] total
);
    timeunit 1ns; timeprecision 1ps;

    logic cnt_ok;

    always_comb begin
        cnt_ok = ((cnt != '0) && (cnt <= CNT_W'(GROUP_MAX))) || (cnt == CNT_W'(GROUP_ALT));
        words  = cnt_ok ? IDX_W'(cnt) : IDX_W'(1);
        unique case (op)
            OP_PLAIN:       total = IDX_W'(1);
            OP_LOAD:        total = IDX_W'(1) + IDX_W'(upd);
            OP_LDM, OP_STM: total = words + IDX_W'(upd);
            default:        total = IDX_W'(2);
        endcase
    end
endmodule

// File: rtl/uopc_gen.sv
module uopc_gen
    import uopc_pkg::*;
(
    input  op_e              op,
    input  logic             upd,
    input  logic [REG_W-1:0] rt,
    input  logic [REG_W-1:0] rs,
    input  logic [REG_W-1:0] ra,
    input  logic [REG_W-1:0] rb,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] words,
    output uop_t             uop
);
    timeunit 1ns; timeprecision 1ps;

    logic             second;
    logic             base_step;
    logic [REG_W-1:0] walk_reg;

    always_comb begin
        second    = (idx != '0);
        base_step = upd && (idx == words);
        walk_reg  = rt + REG_W'(idx);
        uop       = '0;
        unique case (op)
            OP_PLAIN: begin
                uop.wr = rt; uop.we = 1'b1; uop.rd1 = ra; uop.rd2 = rb;
            end
            OP_LOAD: begin
                uop.we = 1'b1; uop.rd1 = ra;
                uop.wr = second ? ra : rt;
            end
            OP_LDM: begin
                uop.we = 1'b1; uop.rd1 = ra;
                uop.wr = base_step ? ra : walk_reg;
            end
            OP_STM: begin
                uop.rd1 = ra;
                if (base_step) begin
                    uop.we = 1'b1; uop.wr = ra;
                end else begin
                    uop.rd2 = walk_reg;
                end
            end
            OP_MOVD: begin
                uop.we  = 1'b1;
                uop.wr  = {rt[REG_W-1:1], second};
                uop.rd1 = {ra[REG_W-1:1], second};
            end
            OP_DIV: begin
                uop.we = 1'b1; uop.rd1 = ra; uop.rd2 = rb;
                uop.wr = second ? rs : rt;
            end
            OP_MAC: begin
                if (second) begin
                    uop.we = 1'b1; uop.wr = rt; uop.rd1 = rt;
                end else begin
                    uop.rd1 = ra; uop.rd2 = rb;
                end
            end
            OP_STRR: begin
                uop.rd1 = ra;
                uop.rd2 = second ? rt : rb;
            end
            default: uop = '0;
        endcase
    end
endmodule

// File: rtl/uopc_seq.sv
module uopc_seq
    import uopc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  instr_t           in_instr,
    output logic             in_ready,
    input  logic             out_ready,
    input  logic [IDX_W-1:0] total,
    output logic             out_valid,
    output logic             out_last,
    output logic [IDX_W-1:0] idx,
    output instr_t           instr_q
);
    timeunit 1ns; timeprecision 1ps;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        instr_t           instr;
    } seq_t;

    seq_t st_d, st_q;
    logic at_last, fire, take;

    always_comb begin
        at_last  = (st_q.idx == total - IDX_W'(1));
        fire     = st_q.busy && out_ready;
        in_ready = !st_q.busy || (fire && at_last);
        take     = in_valid && in_ready;
        st_d     = st_q;
        if (take) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.instr = in_instr;
        end else if (fire) begin
            if (at_last) st_d.busy = 1'b0;
            else         st_d.idx  = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.busy;
    assign out_last  = st_q.busy && at_last;
    assign idx       = st_q.idx;
    assign instr_q   = st_q.instr;

    // R11
    first_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && idx == '0));
    // R11
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_valid && idx == $past(idx) + IDX_W'(1)));
    // R11
    idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idx < total));
    // R12
    no_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && $stable(instr_q)));
    // R13
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(idx) && $stable(instr_q)));
endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
    import uopc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_op,
    input  logic             in_upd,
    input  logic [CNT_W-1:0] in_cnt,
    input  logic [REG_W-1:0] in_rt,
    input  logic [REG_W-1:0] in_rs,
    input  logic [REG_W-1:0] in_ra,
    input  logic [REG_W-1:0] in_rb,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [REG_W-1:0] out_wr_reg,
    output logic             out_wr_en,
    output logic [REG_W-1:0] out_rd1,
    output logic [REG_W-1:0] out_rd2,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_last
);
    timeunit 1ns; timeprecision 1ps;

    instr_t           in_instr;
    instr_t           held;
    logic [IDX_W-1:0] words;
    logic [IDX_W-1:0] total;
    uop_t             uop;

    always_comb begin
        in_instr.op  = op_e'(in_op);
        in_instr.upd = in_upd;
        in_instr.cnt = in_cnt;
        in_instr.rt  = in_rt;
        in_instr.rs  = in_rs;
        in_instr.ra  = in_ra;
        in_instr.rb  = in_rb;
    end

    uopc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_instr  (in_instr),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .total     (total),
        .out_valid (out_valid),
        .out_last  (out_last),
        .idx       (out_idx),
        .instr_q   (held)
    );

    uopc_len u_len (
        .op    (held.op),
        .upd   (held.upd),
        .cnt   (held.cnt),
        .words (words),
        .total (total)
    );

    uopc_gen u_gen (
        .op    (held.op),
        .upd   (held.upd),
        .rt    (held.rt),
        .rs    (held.rs),
        .ra    (held.ra),
        .rb    (held.rb),
        .idx   (out_idx),
        .words (words),
        .uop   (uop)
    );

    assign out_wr_reg = uop.wr;
    assign out_wr_en  = uop.we;
    assign out_rd1    = uop.rd1;
    assign out_rd2    = uop.rd2;
endmodule

// File: tb/tb_uop_cracker.sv
module tb_uop_cracker;
    timeunit 1ns; timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid, in_ready, in_upd;
    logic [2:0] in_op;
    logic [3:0] in_cnt;
    logic [4:0] in_rt, in_rs, in_ra, in_rb;
    logic       out_valid, out_ready, out_wr_en, out_last;
    logic [4:0] out_wr_reg, out_rd1, out_rd2;
    logic [3:0] out_idx;

    uop_cracker dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_upd(in_upd), .in_cnt(in_cnt), .in_rt(in_rt),
        .in_rs(in_rs), .in_ra(in_ra), .in_rb(in_rb), .out_valid(out_valid),
        .out_ready(out_ready), .out_wr_reg(out_wr_reg), .out_wr_en(out_wr_en),
        .out_rd1(out_rd1), .out_rd2(out_rd2), .out_idx(out_idx), .out_last(out_last)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    wr;
        bit    we;
        int    r1;
        int    r2;
        int    idx;
        bit    last;
        string tag;
    } exp_t;

    exp_t pend[$];
    exp_t tmp[$];
    int   n_total = 0;
    int   n_fail  = 0;
    bit   accepted;
    bit   finished = 0;

    task automatic chk(bit ok, string what, int act, int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic void put(int wr, bit we, int r1, int r2, string tag);
        exp_t e;
        e.wr = wr; e.we = we; e.r1 = r1; e.r2 = r2; e.idx = 0; e.last = 0; e.tag = tag;
        tmp.push_back(e);
    endfunction

    function automatic void expand(int op, bit upd, int cnt, int rt, int rs, int ra, int rb);
        int    n;
        string t;
        tmp.delete();
        if ((cnt >= 1 && cnt <= 8) || cnt == 12) begin n = cnt; t = ""; end
        else begin n = 1; t = "R6"; end
        case (op)
            0: put(rt, 1, ra, rb, "R2");
            1: begin
                put(rt, 1, ra, 0, "R3");
                if (upd) put(ra, 1, ra, 0, "R3");
            end
            2: begin
                for (int k = 0; k < n; k++) put((rt + k) % 32, 1, ra, 0, t == "" ? "R4" : t);
                if (upd) put(ra, 1, ra, 0, "R4");
            end
            3: begin
                for (int k = 0; k < n; k++) put(0, 0, ra, (rt + k) % 32, t == "" ? "R5" : t);
                if (upd) put(ra, 1, ra, 0, "R5");
            end
            4: begin
                put(rt & 30, 1, ra & 30, 0, "R7");
                put(rt | 1, 1, ra | 1, 0, "R7");
            end
            5: begin
                put(rt, 1, ra, rb, "R8");
                put(rs, 1, ra, rb, "R8");
            end
            6: begin
                put(0, 0, ra, rb, "R9");
                put(rt, 1, rt, 0, "R9");
            end
            default: begin
                put(0, 0, ra, rb, "R10");
                put(0, 0, ra, rt, "R10");
            end
        endcase
        for (int i = 0; i < tmp.size(); i++) begin
            exp_t e = tmp[i];
            e.idx  = i;
            e.last = (i == tmp.size() - 1);
            pend.push_back(e);
        end
    endfunction

    // inputs are driven just after a falling edge; compare 1 ns later
    task automatic tick();
        bit exp_rdy;
        #1;
        exp_rdy = (pend.size() == 0) || (pend.size() == 1 && out_ready);
        chk(out_valid === (pend.size() != 0), "R12 out_valid", int'(out_valid), int'(pend.size() != 0));
        chk(in_ready === exp_rdy, "R12 in_ready", int'(in_ready), int'(exp_rdy));
        if (out_valid && pend.size() != 0) begin
            exp_t e = pend[0];
            int act_f = {out_wr_reg, out_wr_en, out_rd1, out_rd2};
            int exp_f = {e.wr[4:0], e.we, e.r1[4:0], e.r2[4:0]};
            chk(act_f == exp_f, out_ready ? {e.tag, " fields"} : {e.tag, " R13 fields under stall"}, act_f, exp_f);
            chk({out_idx, out_last} == {e.idx[3:0], e.last}, "R11 index/last",
                int'({out_idx, out_last}), int'({e.idx[3:0], e.last}));
            if (out_ready) void'(pend.pop_front());
        end
        accepted = in_valid && in_ready;
        if (accepted) expand(int'(in_op), in_upd, int'(in_cnt), int'(in_rt), int'(in_rs), int'(in_ra), int'(in_rb));
        @(negedge clk);
    endtask

    task automatic issue(int op, bit upd, int cnt, int rt, int rs, int ra, int rb, bit stall);
        in_valid = 1'b1;
        in_op = 3'(op); in_upd = upd; in_cnt = 4'(cnt);
        in_rt = 5'(rt); in_rs = 5'(rs); in_ra = 5'(ra); in_rb = 5'(rb);
        do begin
            out_ready = stall ? ($urandom % 3 != 0) : 1'b1;
            tick();
        end while (!accepted);
        in_valid = 1'b0;
    endtask

    task automatic drain(bit stall);
        in_valid = 1'b0;
        while (pend.size() != 0) begin
            out_ready = stall ? ($urandom % 2 != 0) : 1'b1;
            tick();
        end
        out_ready = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL R12 watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        in_op = '0; in_upd = 1'b0; in_cnt = '0;
        in_rt = '0; in_rs = '0; in_ra = '0; in_rb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        @(negedge clk);

        // R2 plain ops back to back; in_ready model demands no bubbles
        issue(0, 0, 0, 3, 0, 4, 5, 0);
        issue(0, 0, 0, 6, 0, 7, 8, 0);
        issue(0, 1, 9, 31, 2, 0, 1, 0);
        drain(0);
        // R3
        issue(1, 0, 0, 10, 0, 11, 0, 0);
        issue(1, 1, 0, 12, 0, 13, 0, 0);
        drain(0);
        // R4 and R6
        issue(2, 0, 3, 4, 0, 2, 0, 0);
        issue(2, 1, 8, 16, 0, 1, 0, 0);
        issue(2, 1, 12, 20, 0, 9, 0, 0);
        issue(2, 0, 5, 30, 0, 3, 0, 0);
        issue(2, 1, 1, 5, 0, 6, 0, 0);
        issue(2, 0, 0, 7, 0, 8, 0, 0);
        issue(2, 1, 9, 7, 0, 8, 0, 0);
        issue(2, 0, 15, 7, 0, 8, 0, 0);
        drain(0);
        // R5 and R6
        issue(3, 1, 4, 8, 0, 29, 0, 0);
        issue(3, 0, 12, 25, 0, 2, 0, 0);
        issue(3, 1, 13, 1, 0, 2, 0, 0);
        drain(0);
        // R7 R8 R9 R10
        issue(4, 0, 0, 7, 0, 9, 0, 0);
        issue(4, 0, 0, 2, 0, 4, 0, 0);
        issue(5, 0, 0, 1, 2, 3, 4, 0);
        issue(6, 0, 0, 5, 0, 6, 7, 0);
        issue(7, 0, 0, 8, 0, 9, 10, 0);
        drain(0);
        // R13 directed stall cases
        issue(2, 1, 12, 0, 0, 31, 0, 1);
        issue(5, 0, 0, 11, 12, 13, 14, 1);
        drain(1);
        // random classes, fields and back-pressure
        for (int i = 0; i < 400; i++)
            issue($urandom % 8, 1'($urandom), $urandom % 16, $urandom % 32,
                  $urandom % 32, $urandom % 32, $urandom % 32, 1);
        drain(1);

        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule